// File: doc/BRIEF.md
# Quasi-Resonant Gate Drive Timing Controller

This block decides, cycle by cycle, when the gate drive of a quasi-resonant flyback switch turns on and when it turns off. Its inputs are already-digitized comparator outputs: a zero-crossing pulse train, a level flag that tells whether the ringing amplitude is below its threshold, a feedback-regulation trip, a cycle-by-cycle current-limit trip and a severe-overcurrent trip. A separate up/down counter supplies the number of valleys to wait for before each turn-on. All timers count clock cycles and are set by parameters.

During an on period, the block enforces a leading-edge blanking window in which the trips are ignored, and it caps the on time. During an off period, it first waits out a ringing-suppression window. The window length is picked by the level flag, which is captured when the gate falls. After that window the block counts zero-crossing rising edges and turns the gate on once the count reaches the target. A maximum off time forces a turn-on when too few valleys are seen. A severe-overcurrent condition that persists for a spike-blanking time latches a fault that keeps the gate low until reset.

Top module: `qr_gate_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `gate_o` and `fault_o` are 0. Reset starts an off period with the maximum off-time count at zero and selects the long suppression preset.
- R2: Once `gate_o` rises it stays high for at least LEB_CYC+1 cycles. `fb_trip_i` and `ilim_trip_i` are ignored during the first LEB_CYC cycles of the on period.
- R3: With `fb_trip_i` high in an on-period cycle after blanking, `gate_o` is low from the next clock edge on.
- R4: With `ilim_trip_i` high in an on-period cycle after blanking, `gate_o` is low from the next clock edge on.
- R5: With no trips, `gate_o` stays high for exactly TON_MAX_CYC cycles and is then forced low.
- R6: After `gate_o` falls, it stays low for at least the suppression length: RS_LONG_CYC when `zc_low_i` was 1 at the falling edge, and RS_SHORT_CYC when it was 0.
- R7: A valley count is cleared while the gate is high. It counts rising edges of `zc_pulse_i` (0 in one cycle, 1 in the next) only once suppression has ended, and it saturates. The gate turns on two edges after the edge that makes the count reach `valley_target_i`. A target of 0 turns the gate on at the edge after suppression ends.
- R8: After TOFF_MAX_CYC cycles low, `gate_o` goes high regardless of the valley count and of `zc_low_i`.
- R9: `short_trip_i` high for SC_BLANK_CYC consecutive cycles sets `fault_o`, while shorter bursts have no effect. From the next edge on, `gate_o` is held low, and `fault_o` stays set until reset.
- R10: Changes of `zc_low_i` while the gate is low do not change the suppression length of that off period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| zc_pulse_i | input | 1 | Zero-crossing comparator output |
| zc_low_i | input | 1 | 1 when the ringing level is below its threshold |
| fb_trip_i | input | 1 | Scaled current above the regulation level |
| ilim_trip_i | input | 1 | Cycle-by-cycle current-limit comparator |
| short_trip_i | input | 1 | Severe-overcurrent comparator |
| valley_target_i | input | VALLEY_W | Valley count needed for turn-on |
| gate_o | output | 1 | Gate drive |
| fault_o | output | 1 | Latched severe-overcurrent fault |

## Verification
The bench builds the block with blanking 4, maximum on time 20, suppression presets 8 and 3, maximum off time 40, spike blanking 3 and a 4-bit valley target. With these short values, every path to turn-on fits into a few dozen cycles: the suppression-only path with target 0, the valley-count path under both presets, and the maximum off-time override reached with target 15. The exact on and off lengths can then be checked edge by edge, including a level flag flipped mid-period and a two-cycle overcurrent burst that must not latch.

// File: rtl/qr_gate_pkg.sv
package qr_gate_pkg;

    typedef enum logic {
        SUPP_SHORT = 1'b0,
        SUPP_LONG  = 1'b1
    } supp_sel_e;

    typedef struct packed {
        logic fb;
        logic ilim;
    } trip_t;

    typedef struct packed {
        logic on_req;
        logic supp_done;
        logic max_off;
    } off_stat_t;

    function automatic logic any_trip(input trip_t t);
        return t.fb | t.ilim;
    endfunction

    function automatic supp_sel_e pick_supp(input logic level_low);
        return level_low ? SUPP_LONG : SUPP_SHORT;
    endfunction

endpackage

// File: rtl/qr_on_timer.sv
module qr_on_timer
    import qr_gate_pkg::*;
#(
    parameter int LEB_CYC     = 4,
    parameter int TON_MAX_CYC = 20
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  gate_q,
    input  trip_t trip_i,
    output logic  blank_o,
    output logic  off_req_o
);
    localparam int ON_W = $clog2(TON_MAX_CYC + 1);
    localparam logic [ON_W-1:0] LEB_V   = ON_W'(LEB_CYC);
    localparam logic [ON_W-1:0] ON_LAST = ON_W'(TON_MAX_CYC - 1);
    localparam logic [ON_W-1:0] ON_SAT  = {ON_W{1'b1}};

    logic [ON_W-1:0] on_cnt;

    always_ff @(posedge clk) begin
        if (rst || !gate_q) begin
            on_cnt <= '0;
        end else if (on_cnt != ON_SAT) begin
            on_cnt <= on_cnt + 1'b1;
        end
    end

    always_comb begin
        blank_o   = gate_q && (on_cnt < LEB_V);
        off_req_o = gate_q && (((on_cnt >= LEB_V) && any_trip(trip_i)) ||
                               (on_cnt == ON_LAST));
    end

    // R5
    max_on_chk: assert property (@(posedge clk) disable iff (rst)
        (gate_q && on_cnt == ON_LAST) |=> !gate_q);

endmodule

// File: rtl/qr_off_timer.sv
module qr_off_timer
    import qr_gate_pkg::*;
#(
    parameter int RS_LONG_CYC  = 8,
    parameter int RS_SHORT_CYC = 3,
    parameter int TOFF_MAX_CYC = 40,
    parameter int VALLEY_W     = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                gate_q,
    input  logic                zc_i,
    input  logic                zc_low_i,
    input  logic [VALLEY_W-1:0] target_i,
    output off_stat_t           stat_o
);
    localparam int OFF_W = $clog2(TOFF_MAX_CYC + 1);
    localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(TOFF_MAX_CYC - 1);
    localparam logic [OFF_W-1:0] OFF_SAT  = {OFF_W{1'b1}};
    localparam logic [OFF_W-1:0] RS_L     = OFF_W'(RS_LONG_CYC);
    localparam logic [OFF_W-1:0] RS_S     = OFF_W'(RS_SHORT_CYC);
    localparam logic [VALLEY_W-1:0] V_SAT = {VALLEY_W{1'b1}};

    logic [OFF_W-1:0]    off_cnt;
    logic [VALLEY_W-1:0] vcnt;
    logic                zc_prev;
    supp_sel_e           supp_sel;
    logic [OFF_W-1:0]    supp_len;
    logic                zc_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            supp_sel <= SUPP_LONG;
        end else if (gate_q) begin
            supp_sel <= pick_supp(zc_low_i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || gate_q) begin
            off_cnt <= '0;
        end else if (off_cnt != OFF_SAT) begin
            off_cnt <= off_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            zc_prev <= 1'b0;
        end else begin
            zc_prev <= zc_i;
        end
    end

    always_comb begin
        supp_len         = (supp_sel == SUPP_LONG) ? RS_L : RS_S;
        zc_rise          = zc_i && !zc_prev;
        stat_o.supp_done = !gate_q && (off_cnt >= supp_len);
        stat_o.max_off   = !gate_q && (off_cnt == OFF_LAST);
        stat_o.on_req    = (stat_o.supp_done && (vcnt >= target_i)) || stat_o.max_off;
    end

    always_ff @(posedge clk) begin
        if (rst || gate_q) begin
            vcnt <= '0;
        end else if (stat_o.supp_done && zc_rise && vcnt != V_SAT) begin
            vcnt <= vcnt + 1'b1;
        end
    end

    // R7
    valley_clr_chk: assert property (@(posedge clk) disable iff (rst)
        gate_q |=> (vcnt == '0));

    // R7
    valley_nowrap_chk: assert property (@(posedge clk) disable iff (rst)
        (!gate_q && vcnt == V_SAT) |=> (gate_q || vcnt == V_SAT));

endmodule

// File: rtl/qr_fault_filter.sv
module qr_fault_filter #(
    parameter int SC_BLANK_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic short_i,
    output logic fault_o
);
    localparam int SC_W = $clog2(SC_BLANK_CYC + 1);
    localparam logic [SC_W-1:0] SC_LAST = SC_W'(SC_BLANK_CYC - 1);

    logic [SC_W-1:0] sc_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sc_cnt  <= '0;
            fault_o <= 1'b0;
        end else if (!short_i) begin
            sc_cnt <= '0;
        end else if (sc_cnt == SC_LAST) begin
            fault_o <= 1'b1;
        end else begin
            sc_cnt <= sc_cnt + 1'b1;
        end
    end

    // R9
    fault_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        fault_o |=> fault_o);

    // R9
    fault_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!fault_o && !short_i) |=> !fault_o);

endmodule

// File: rtl/qr_gate_ctrl.sv
module qr_gate_ctrl
    import qr_gate_pkg::*;
#(
    parameter int LEB_CYC      = 4,
    parameter int TON_MAX_CYC  = 20,
    parameter int RS_LONG_CYC  = 8,
    parameter int RS_SHORT_CYC = 3,
    parameter int TOFF_MAX_CYC = 40,
    parameter int SC_BLANK_CYC = 3,
    parameter int VALLEY_W     = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                zc_pulse_i,
    input  logic                zc_low_i,
    input  logic                fb_trip_i,
    input  logic                ilim_trip_i,
    input  logic                short_trip_i,
    input  logic [VALLEY_W-1:0] valley_target_i,
    output logic                gate_o,
    output logic                fault_o
);
    logic      gate_q;
    logic      gate_d;
    logic      fault_q;
    logic      blank;
    logic      off_req;
    trip_t     trip;
    off_stat_t ostat;

    assign trip.fb   = fb_trip_i;
    assign trip.ilim = ilim_trip_i;

    qr_on_timer #(
        .LEB_CYC     (LEB_CYC),
        .TON_MAX_CYC (TON_MAX_CYC)
    ) u_on (
        .clk       (clk),
        .rst       (rst),
        .gate_q    (gate_q),
        .trip_i    (trip),
        .blank_o   (blank),
        .off_req_o (off_req)
    );

    qr_off_timer #(
        .RS_LONG_CYC  (RS_LONG_CYC),
        .RS_SHORT_CYC (RS_SHORT_CYC),
        .TOFF_MAX_CYC (TOFF_MAX_CYC),
        .VALLEY_W     (VALLEY_W)
    ) u_off (
        .clk      (clk),
        .rst      (rst),
        .gate_q   (gate_q),
        .zc_i     (zc_pulse_i),
        .zc_low_i (zc_low_i),
        .target_i (valley_target_i),
        .stat_o   (ostat)
    );

    qr_fault_filter #(
        .SC_BLANK_CYC (SC_BLANK_CYC)
    ) u_fault (
        .clk     (clk),
        .rst     (rst),
        .short_i (short_trip_i),
        .fault_o (fault_q)
    );

    always_comb begin
        if (fault_q) begin
            gate_d = 1'b0;
        end else if (gate_q) begin
            gate_d = !off_req;
        end else begin
            gate_d = ostat.on_req;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= 1'b0;
        end else begin
            gate_q <= gate_d;
        end
    end

    assign gate_o  = gate_q;
    assign fault_o = fault_q;

    // R2
    leb_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (gate_q && blank && !fault_q) |=> gate_q);

    // R6
    supp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!gate_q && !ostat.supp_done) |=> !gate_q);

    // R8
    max_off_chk: assert property (@(posedge clk) disable iff (rst)
        (ostat.max_off && !fault_q) |=> gate_q);

    // R9
    fault_gate_chk: assert property (@(posedge clk) disable iff (rst)
        fault_q |=> !gate_q);

endmodule

// File: tb/qr_gate_ctrl_bench.sv
module qr_gate_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       zc = 1'b0;
    logic       zc_low = 1'b0;
    logic       fb = 1'b0;
    logic       ilim = 1'b0;
    logic       short_t = 1'b0;
    logic [3:0] target = 4'd15;
    logic       gate;
    logic       fault;

    int checks = 0;
    int fails  = 0;

    // fields: [11] level flag at fall, [10] use ilim trip, [9:6] target, [5:0] expected off length
    localparam logic [11:0] VECS [6] = '{
        {1'b1, 1'b0, 4'd2,  6'd14},
        {1'b0, 1'b1, 4'd2,  6'd8},
        {1'b0, 1'b0, 4'd0,  6'd4},
        {1'b1, 1'b1, 4'd0,  6'd9},
        {1'b1, 1'b0, 4'd15, 6'd40},
        {1'b0, 1'b1, 4'd5,  6'd17}
    };

    qr_gate_ctrl u_qr_gate_ctrl (
        .clk             (clk),
        .rst             (rst),
        .zc_pulse_i      (zc),
        .zc_low_i        (zc_low),
        .fb_trip_i       (fb),
        .ilim_trip_i     (ilim),
        .short_trip_i    (short_t),
        .valley_target_i (target),
        .gate_o          (gate),
        .fault_o         (fault)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) step();
        chk("R1 gate in reset", gate, 1'b0);
        chk("R1 fault in reset", fault, 1'b0);
        rst = 1'b0;
        // R8 / R1: off count starts at reset, target unreachable
        for (int n = 1; n <= 40; n++) begin
            step();
            if (n == 1) chk("R1 gate after reset", gate, 1'b0);
            if (n == 39) chk("R8 before max off", gate, 1'b0);
            if (n == 40) chk("R8 max off turn-on", gate, 1'b1);
        end
        target = 4'd0;
        // R5: no trips, on time capped
        for (int m = 1; m <= 20; m++) begin
            step();
            if (m == 19) chk("R5 high before cap", gate, 1'b1);
            if (m == 20) chk("R5 forced low", gate, 1'b0);
        end
        // short preset (flag 0), target 0: on after 4 edges
        for (int k = 1; k <= 4; k++) begin
            step();
            chk("R7 target zero", gate, (k == 4) ? 1'b1 : 1'b0);
        end

        // table walk: each entry one on period then one off period
        for (int v = 0; v < 6; v++) begin
            logic [11:0] e;
            int          len;
            e      = VECS[v];
            len    = int'(e[5:0]);
            zc_low = e[11];
            target = e[9:6];
            if (e[10]) ilim = 1'b1; else fb = 1'b1;
            repeat (4) step();
            chk("R2 trip ignored in blanking", gate, 1'b1);
            step();
            chk(e[10] ? "R4 ilim trip" : "R3 fb trip", gate, 1'b0);
            fb     = 1'b0;
            ilim   = 1'b0;
            zc_low = ~e[11];   // R10: flip after fall
            zc     = 1'b1;
            for (int k = 1; k <= len; k++) begin
                step();
                zc = ((k % 3) == 0 && k < len) ? 1'b1 : 1'b0;
                if (k < len) chk("R6 R7 R10 off length", gate, 1'b0);
                else         chk("R7 R8 turn-on", gate, 1'b1);
            end
        end

        // R9: glitch then sustained overcurrent, starting at a rising edge
        target  = 4'd0;
        short_t = 1'b1;
        step();
        step();
        short_t = 1'b0;
        chk("R9 short burst ignored", fault, 1'b0);
        step();
        short_t = 1'b1;
        chk("R9 no fault after burst", fault, 1'b0);
        step();
        step();
        chk("R9 before blank end", fault, 1'b0);
        step();
        chk("R9 fault latched", fault, 1'b1);
        chk("R9 gate still high", gate, 1'b1);
        step();
        chk("R9 gate forced low", gate, 1'b0);
        short_t = 1'b0;
        begin
            logic seen_high;
            seen_high = 1'b0;
            repeat (60) begin
                step();
                if (gate) seen_high = 1'b1;
            end
            chk("R9 gate held low", seen_high, 1'b0);
        end
        chk("R9 fault sticky", fault, 1'b1);

        // R1: reset clears fault, long preset after reset
        rst = 1'b1;
        step();
        chk("R1 fault cleared", fault, 1'b0);
        chk("R1 gate low", gate, 1'b0);
        rst    = 1'b0;
        zc_low = 1'b0;
        for (int n = 1; n <= 9; n++) begin
            step();
            if (n == 8) chk("R1 long preset after reset", gate, 1'b0);
            if (n == 9) chk("R1 R6 on after long preset", gate, 1'b1);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule